// File: doc/BRIEF.md
# Set-Associative TLB Command Engine

This block holds a set-associative table of address translations and is driven through a small register-style command port. Software first fills three holding registers: a tag descriptor, a data descriptor and an index register. It then pulses a command. A probe searches the set that the tag's page number selects and reports where the entry is, or why it cannot say. A get-index picks a slot for a new entry. The two write commands commit both descriptors at the indexed slot; one of them also signals the micro-TLBs to drop their contents. A read copies an entry back into the descriptor registers. A separate invalidate command only raises the micro-TLB pulse.

Alongside the command port, a combinational translate port looks up a page number and an address-space ID and returns the frame number and access bits of the matching entry. Entries are numbered linearly, set-major: the ways of one set take consecutive numbers. Every command completes in a single cycle, so there is no busy flag. The strobe has no ready and is never back-pressured: each command given on a cycle is taken on that cycle.

Top module: `tlb_cmd_engine`

## Requirements
- R1: After a synchronous active-low reset, the index register, both descriptor registers and the micro-TLB pulse read zero, and no entry is valid, so every translate lookup misses.
- R2: A register write with select 0 loads the tag descriptor, select 1 the data descriptor and select 2 the index register. Each value is visible on the outputs in the next cycle. Select 3 changes nothing. Tag layout: asid [7:0], global bit [8], valid bit [9], page number from bit 10 up. Data layout: access bits [5:0], frame number from bit 6 up.
- R3: Command code 1 (probe) compares the page number and ASID in the tag register against the ways of its set. An entry matches when its valid bit is set, its page number is equal and either its global bit is set or its ASID is equal. On exactly one match, the index register becomes the linear index of that entry, with both error bits clear, in the next cycle.
- R4: A probe with no match loads the index register with only the lookup-error bit (bit IDX_W+1) set.
- R5: A probe with more than one match loads the index register with the lookup-error bit and the duplicate bit (bit IDX_W) set and all index bits zero. Duplicates are never refused on write.
- R6: Command code 2 (get-index) loads the index of the lowest-numbered invalid way in the tag's set, with both error bits clear.
- R7: When every way of that set is valid, get-index returns a round-robin victim way. The victim starts at way 0 and advances by one only on each get-index that uses it.
- R8: Command code 3 (write) stores the tag and data registers at the entry named by the low index bits. It raises the micro-TLB pulse for exactly the next cycle.
- R9: Command code 4 (write without invalidate) stores the entry the same way and leaves the pulse low.
- R10: Command code 5 (read) loads both descriptor registers from the entry named by the index register in the next cycle.
- R11: Command code 6 raises the micro-TLB pulse for one cycle and changes no register.
- R12: The translate port answers combinationally with hit, frame number and access bits, using the same match rule. When several ways match, the lowest-numbered way is returned.
- R13: The set is the low log2(SETS) bits of the page number, and the linear index is set × WAYS + way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr_en | input | 1 | Holding-register write strobe |
| reg_sel | input | 2 | Register select: 0 tag, 1 data, 2 index |
| reg_wdata | input | TAG_W | Register write value (lower bits used for narrower registers) |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 3 | Command code |
| index_q | output | IDX_W+2 | Index register: lookup-error bit, duplicate bit, linear index |
| tag_q | output | TAG_W | Tag descriptor register |
| data_q | output | DATA_W | Data descriptor register |
| uinv_pulse | output | 1 | One-cycle micro-TLB invalidate request |
| xl_vpn | input | VPN_W | Translate: page number |
| xl_asid | input | 8 | Translate: address-space ID |
| xl_hit | output | 1 | Translate: match found |
| xl_pfn | output | PFN_W | Translate: frame number |
| xl_perm | output | 6 | Translate: access bits |

## Verification
Register writes and commands are registered. Their effect on the index register, the descriptor registers and the invalidate pulse is due in the cycle after the strobe. Translate results are combinational and are due within the same cycle as the address.

The bench drives inputs on the falling edge and samples the outputs one falling edge later. It steps a behavioural model on each rising edge and compares it against the registered outputs on every falling edge. Translate answers are checked a short delay after the lookup inputs change.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int ASID_W      = 8;
  localparam int TAG_GLB     = 8;
  localparam int TAG_VLD     = 9;
  localparam int TAG_VPN_LSB = 10;
  localparam int PERM_W      = 6;

  typedef enum logic [2:0] {
    OP_NONE     = 3'd0,
    OP_PROBE    = 3'd1,
    OP_GETIDX   = 3'd2,
    OP_WRITE    = 3'd3,
    OP_WRITE_NI = 3'd4,
    OP_READ     = 3'd5,
    OP_UINV     = 3'd6
  } tlb_op_e;

  typedef enum logic [1:0] {
    SEL_TAG   = 2'd0,
    SEL_DATA  = 2'd1,
    SEL_INDEX = 2'd2
  } reg_sel_e;

  // Lowest set bit of a vector of up to 32 bits; 0 when none is set.
  function automatic int unsigned first_one(input logic [31:0] v);
    int unsigned r;
    r = 0;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction
endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store #(
  parameter int SETS   = 128,
  parameter int WAYS   = 2,
  parameter int TAG_W  = 29,
  parameter int DATA_W = 26,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int IDX_W = SET_W + WAY_W,
  localparam int N     = SETS * WAYS
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [IDX_W-1:0]              wr_idx,
  input  logic [TAG_W-1:0]              wr_tag,
  input  logic [DATA_W-1:0]             wr_data,
  input  logic [IDX_W-1:0]              rd_idx,
  output logic [TAG_W-1:0]              rd_tag,
  output logic [DATA_W-1:0]             rd_data,
  input  logic [SET_W-1:0]              set_a,
  output logic [WAYS-1:0][TAG_W-1:0]    a_tags,
  input  logic [SET_W-1:0]              set_b,
  output logic [WAYS-1:0][TAG_W-1:0]    b_tags,
  output logic [WAYS-1:0][DATA_W-1:0]   b_data
);
  logic [TAG_W-1:0]  tag_mem  [N];
  logic [DATA_W-1:0] data_mem [N];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        tag_mem[i]  <= '0;
        data_mem[i] <= '0;
      end
    end else if (wr_en) begin
      tag_mem[wr_idx]  <= wr_tag;
      data_mem[wr_idx] <= wr_data;
    end
  end

  assign rd_tag  = tag_mem[rd_idx];
  assign rd_data = data_mem[rd_idx];

  // Set-major numbering: {set, way} equals set*WAYS+way for power-of-two WAYS.
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    localparam logic [WAY_W-1:0] WSEL = WAY_W'(w);
    assign a_tags[w] = tag_mem[{set_a, WSEL}];
    assign b_tags[w] = tag_mem[{set_b, WSEL}];
    assign b_data[w] = data_mem[{set_b, WSEL}];
  end
endmodule

// File: rtl/tlb_way_match.sv
module tlb_way_match
  import tlb_pkg::*;
#(
  parameter int WAYS  = 2,
  parameter int VPN_W = 19,
  localparam int TAG_W = VPN_W + TAG_VPN_LSB
) (
  input  logic [WAYS-1:0][TAG_W-1:0] way_tags,
  input  logic [VPN_W-1:0]           key_vpn,
  input  logic [ASID_W-1:0]          key_asid,
  output logic [WAYS-1:0]            hit_vec
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    logic vpn_eq, asid_ok;
    assign vpn_eq  = way_tags[w][TAG_VPN_LSB +: VPN_W] == key_vpn;
    assign asid_ok = way_tags[w][TAG_GLB] || (way_tags[w][ASID_W-1:0] == key_asid);
    assign hit_vec[w] = way_tags[w][TAG_VLD] && vpn_eq && asid_ok;
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int WAYS = 2,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [WAY_W-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (!rst_n)   ptr <= '0;
    else if (adv) ptr <= ptr + 1'b1;
  end
endmodule

// File: rtl/tlb_cmd_engine.sv
module tlb_cmd_engine
  import tlb_pkg::*;
#(
  parameter int SETS  = 128,
  parameter int WAYS  = 2,
  parameter int VPN_W = 19,
  parameter int PFN_W = 20,
  localparam int SET_W  = $clog2(SETS),
  localparam int WAY_W  = $clog2(WAYS),
  localparam int IDX_W  = SET_W + WAY_W,
  localparam int TAG_W  = VPN_W + TAG_VPN_LSB,
  localparam int DATA_W = PFN_W + PERM_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [1:0]        reg_sel,
  input  logic [TAG_W-1:0]  reg_wdata,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  output logic [IDX_W+1:0]  index_q,
  output logic [TAG_W-1:0]  tag_q,
  output logic [DATA_W-1:0] data_q,
  output logic              uinv_pulse,
  input  logic [VPN_W-1:0]  xl_vpn,
  input  logic [ASID_W-1:0] xl_asid,
  output logic              xl_hit,
  output logic [PFN_W-1:0]  xl_pfn,
  output logic [PERM_W-1:0] xl_perm
);
  localparam int ERR_BIT = IDX_W + 1;
  localparam int DUP_BIT = IDX_W;

  tlb_op_e op;
  assign op = tlb_op_e'(cmd_op);

  logic [SET_W-1:0]               probe_set;
  logic [VPN_W-1:0]               probe_vpn;
  logic [WAYS-1:0][TAG_W-1:0]     probe_tags;
  logic [WAYS-1:0][TAG_W-1:0]     xl_tags;
  logic [WAYS-1:0][DATA_W-1:0]    xl_datas;
  logic [WAYS-1:0]                probe_hits, xl_hits, free_vec;
  logic [TAG_W-1:0]               rd_tag;
  logic [DATA_W-1:0]              rd_data;
  logic [WAY_W-1:0]               victim, hit_way, free_way, xl_way;
  logic                           store_wr, victim_adv;

  assign probe_vpn = tag_q[TAG_VPN_LSB +: VPN_W];
  assign probe_set = probe_vpn[SET_W-1:0];
  assign store_wr  = cmd_valid && (op == OP_WRITE || op == OP_WRITE_NI);

  tlb_entry_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(store_wr), .wr_idx(index_q[IDX_W-1:0]), .wr_tag(tag_q), .wr_data(data_q),
    .rd_idx(index_q[IDX_W-1:0]), .rd_tag(rd_tag), .rd_data(rd_data),
    .set_a(probe_set), .a_tags(probe_tags),
    .set_b(xl_vpn[SET_W-1:0]), .b_tags(xl_tags), .b_data(xl_datas)
  );

  tlb_way_match #(.WAYS(WAYS), .VPN_W(VPN_W)) u_probe_cmp (
    .way_tags(probe_tags), .key_vpn(probe_vpn), .key_asid(tag_q[ASID_W-1:0]),
    .hit_vec(probe_hits)
  );

  tlb_way_match #(.WAYS(WAYS), .VPN_W(VPN_W)) u_xl_cmp (
    .way_tags(xl_tags), .key_vpn(xl_vpn), .key_asid(xl_asid), .hit_vec(xl_hits)
  );

  tlb_victim #(.WAYS(WAYS)) u_victim (
    .clk(clk), .rst_n(rst_n), .adv(victim_adv), .ptr(victim)
  );

  always_comb begin
    for (int w = 0; w < WAYS; w++) free_vec[w] = !probe_tags[w][TAG_VLD];
  end

  assign hit_way    = WAY_W'(first_one(32'(probe_hits)));
  assign free_way   = WAY_W'(first_one(32'(free_vec)));
  assign xl_way     = WAY_W'(first_one(32'(xl_hits)));
  assign victim_adv = cmd_valid && (op == OP_GETIDX) && !(|free_vec);

  // Translate port
  assign xl_hit  = |xl_hits;
  assign xl_pfn  = xl_hit ? xl_datas[xl_way][PERM_W +: PFN_W] : '0;
  assign xl_perm = xl_hit ? xl_datas[xl_way][PERM_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      index_q    <= '0;
      tag_q      <= '0;
      data_q     <= '0;
      uinv_pulse <= 1'b0;
    end else begin
      uinv_pulse <= cmd_valid && (op == OP_WRITE || op == OP_UINV);
      if (reg_wr_en) begin
        case (reg_sel_e'(reg_sel))
          SEL_TAG:   tag_q   <= reg_wdata;
          SEL_DATA:  data_q  <= reg_wdata[DATA_W-1:0];
          SEL_INDEX: index_q <= reg_wdata[IDX_W+1:0];
          default: ;
        endcase
      end
      if (cmd_valid) begin
        case (op)
          OP_PROBE: begin
            if ($countones(probe_hits) > 1)  index_q <= {2'b11, {IDX_W{1'b0}}};
            else if (|probe_hits)            index_q <= {2'b00, probe_set, hit_way};
            else                             index_q <= {2'b10, {IDX_W{1'b0}}};
          end
          OP_GETIDX: index_q <= {2'b00, probe_set, (|free_vec) ? free_way : victim};
          OP_READ: begin
            tag_q  <= rd_tag;
            data_q <= rd_data;
          end
          default: ;
        endcase
      end
    end
  end

  // R3
  probe_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && op == OP_PROBE && $countones(probe_hits) == 1)
      |=> (rd_tag[TAG_VLD] && !index_q[ERR_BIT]));

  // R5
  probe_dup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && op == OP_PROBE && $countones(probe_hits) > 1)
      |=> (index_q[ERR_BIT] && index_q[DUP_BIT]));

  // R6
  getidx_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && op == OP_GETIDX && (|free_vec)) |=> !rd_tag[TAG_VLD]);

  // R9
  wrni_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && op == OP_WRITE_NI) |=> !uinv_pulse);

  // R11
  uinv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && op == OP_UINV && !reg_wr_en)
      |=> (uinv_pulse && $stable(index_q) && $stable(tag_q) && $stable(data_q)));
endmodule

// File: tb/tlb_cmd_engine_test.sv
`timescale 1ns/100ps
module tlb_cmd_engine_test;
  localparam int SETS = 128, WAYS = 2, VPN_W = 19, PFN_W = 20;
  localparam int N = SETS * WAYS;
  localparam int TAG_W = VPN_W + 10, DATA_W = PFN_W + 6, IDX_W = 8;

  logic clk = 0, rst_n = 0;
  logic reg_wr_en = 0, cmd_valid = 0;
  logic [1:0] reg_sel = 0;
  logic [TAG_W-1:0] reg_wdata = 0;
  logic [2:0] cmd_op = 0;
  logic [IDX_W+1:0] index_q;
  logic [TAG_W-1:0] tag_q;
  logic [DATA_W-1:0] data_q;
  logic uinv_pulse;
  logic [VPN_W-1:0] xl_vpn = 0;
  logic [7:0] xl_asid = 0;
  logic xl_hit;
  logic [PFN_W-1:0] xl_pfn;
  logic [5:0] xl_perm;

  tlb_cmd_engine uut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .index_q(index_q), .tag_q(tag_q), .data_q(data_q),
    .uinv_pulse(uinv_pulse), .xl_vpn(xl_vpn), .xl_asid(xl_asid), .xl_hit(xl_hit),
    .xl_pfn(xl_pfn), .xl_perm(xl_perm)
  );

  always #2.5 clk = ~clk;

  int checks = 0, failures = 0;
  bit finished = 0, started = 0;
  string cur_req = "R1";

  // Behavioural reference model
  logic [TAG_W-1:0]  m_tag [N];
  logic [DATA_W-1:0] m_data [N];
  logic [IDX_W+1:0]  m_idx, o_idx;
  logic [TAG_W-1:0]  m_tr, o_tr;
  logic [DATA_W-1:0] m_dr, o_dr;
  bit m_pulse;
  int m_rr, m_set, m_cnt, m_first, m_free, m_e;

  function automatic bit ent_match(logic [TAG_W-1:0] t, logic [VPN_W-1:0] vpn, logic [7:0] asid);
    return t[9] && t[TAG_W-1:10] == vpn && (t[8] || t[7:0] == asid);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin m_tag[i] = 0; m_data[i] = 0; end
      m_idx = 0; m_tr = 0; m_dr = 0; m_pulse = 0; m_rr = 0;
    end else begin
      o_idx = m_idx; o_tr = m_tr; o_dr = m_dr;
      m_pulse = cmd_valid && (cmd_op == 3 || cmd_op == 6);
      if (reg_wr_en) begin
        if (reg_sel == 0) m_tr = reg_wdata;
        else if (reg_sel == 1) m_dr = reg_wdata[DATA_W-1:0];
        else if (reg_sel == 2) m_idx = reg_wdata[IDX_W+1:0];
      end
      if (cmd_valid) begin
        m_set = int'(o_tr[16:10]);
        if (cmd_op == 1) begin
          m_cnt = 0; m_first = 0;
          for (int w = WAYS - 1; w >= 0; w--) begin
            m_e = m_set * WAYS + w;
            if (ent_match(m_tag[m_e], o_tr[TAG_W-1:10], o_tr[7:0])) begin m_cnt++; m_first = m_e; end
          end
          if (m_cnt > 1) m_idx = 10'h300;
          else if (m_cnt == 1) m_idx = 10'(m_first);
          else m_idx = 10'h200;
        end else if (cmd_op == 2) begin
          m_free = -1;
          for (int w = WAYS - 1; w >= 0; w--)
            if (!m_tag[m_set * WAYS + w][9]) m_free = w;
          if (m_free < 0) begin m_free = m_rr; m_rr = (m_rr + 1) % WAYS; end
          m_idx = 10'(m_set * WAYS + m_free);
        end else if (cmd_op == 3 || cmd_op == 4) begin
          m_tag[o_idx[7:0]] = o_tr; m_data[o_idx[7:0]] = o_dr;
        end else if (cmd_op == 5) begin
          m_tr = m_tag[o_idx[7:0]]; m_dr = m_data[o_idx[7:0]];
        end
      end
      started = 1;
    end
  end

  // Every-cycle comparison of the registered outputs
  always @(negedge clk) begin
    if (started && !finished) begin
      checks++;
      if (index_q !== m_idx || tag_q !== m_tr || data_q !== m_dr || uinv_pulse !== m_pulse) begin
        failures++;
        $display("FAIL %s cycle compare: idx=%h tag=%h data=%h pulse=%b expected idx=%h tag=%h data=%h pulse=%b",
                 cur_req, index_q, tag_q, data_q, uinv_pulse, m_idx, m_tr, m_dr, m_pulse);
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(logic [1:0] sel, logic [TAG_W-1:0] val);
    @(negedge clk); reg_wr_en = 1; reg_sel = sel; reg_wdata = val;
    @(negedge clk); reg_wr_en = 0;
  endtask

  task automatic cmd(logic [2:0] op);
    @(negedge clk); cmd_valid = 1; cmd_op = op;
    @(negedge clk); cmd_valid = 0; cmd_op = 0;
  endtask

  task automatic xl_chk(string req, logic [VPN_W-1:0] vpn, logic [7:0] asid,
                        logic hit, logic [PFN_W-1:0] pfn, logic [5:0] perm);
    xl_vpn = vpn; xl_asid = asid; #1;
    chk(req, {5'd0, xl_hit, xl_perm, xl_pfn}, {5'd0, hit, perm, pfn});
  endtask

  function automatic logic [TAG_W-1:0] mk_tag(logic [VPN_W-1:0] v, bit vld, bit g, logic [7:0] a);
    return {v, vld, g, a};
  endfunction

  localparam logic [VPN_W-1:0] VA = 19'h00105, VB = 19'h00285, VC = 19'h0000A, VD = 19'h00006;
  localparam logic [DATA_W-1:0] DA = {20'hABCDE, 6'h2D}, DB = {20'h12345, 6'h07},
                                DC0 = {20'h0C0C0, 6'h11}, DC1 = {20'h0C1C1, 6'h22};

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      finished = 1; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cur_req = "R1";
    chk("R1 index", 32'(index_q), 0);
    chk("R1 tag", 32'(tag_q), 0);
    chk("R1 data", 32'(data_q), 0);
    chk("R1 pulse", 32'(uinv_pulse), 0);
    xl_chk("R1 empty translate", VA, 8'h03, 0, 0, 0);

    cur_req = "R2";
    reg_wr(0, mk_tag(VA, 1, 0, 8'h03));
    chk("R2 tag load", 32'(tag_q), 32'(mk_tag(VA, 1, 0, 8'h03)));
    reg_wr(1, TAG_W'(DA));
    chk("R2 data load", 32'(data_q), 32'(DA));
    reg_wr(3, '1);
    chk("R2 select 3 ignored tag", 32'(tag_q), 32'(mk_tag(VA, 1, 0, 8'h03)));
    chk("R2 select 3 ignored data", 32'(data_q), 32'(DA));
    chk("R2 select 3 ignored index", 32'(index_q), 0);

    cur_req = "R6";
    cmd(2);
    chk("R6 R13 getidx free way0 of set5", 32'(index_q), 10);
    cur_req = "R8";
    cmd(3);
    chk("R8 write pulse", 32'(uinv_pulse), 1);
    @(negedge clk);
    chk("R8 pulse one cycle", 32'(uinv_pulse), 0);
    xl_chk("R12 translate hit", VA, 8'h03, 1, DA[25:6], DA[5:0]);
    xl_chk("R12 translate asid mismatch", VA, 8'h04, 0, 0, 0);

    cur_req = "R3";
    cmd(1);
    chk("R3 probe hit", 32'(index_q), 10);
    cur_req = "R4";
    reg_wr(0, mk_tag(VA, 1, 0, 8'h04));
    cmd(1);
    chk("R4 probe miss", 32'(index_q), 32'h200);

    cur_req = "R9";
    reg_wr(0, mk_tag(VB, 1, 1, 8'h07));
    reg_wr(1, TAG_W'(DB));
    cmd(2);
    chk("R6 getidx next free way", 32'(index_q), 11);
    cmd(4);
    chk("R9 write_ni no pulse", 32'(uinv_pulse), 0);
    xl_chk("R12 global translate", VB, 8'h55, 1, DB[25:6], DB[5:0]);
    cur_req = "R3";
    reg_wr(0, mk_tag(VB, 0, 0, 8'h99));
    cmd(1);
    chk("R3 probe global entry", 32'(index_q), 11);

    cur_req = "R7";
    cmd(2);
    chk("R7 victim way0", 32'(index_q), 10);
    cmd(2);
    chk("R7 victim way1", 32'(index_q), 11);
    reg_wr(0, mk_tag(VD, 1, 0, 8'h01));
    cmd(2);
    chk("R6 free set6 no victim use", 32'(index_q), 12);
    reg_wr(0, mk_tag(VB, 1, 0, 8'h01));
    cmd(2);
    chk("R7 victim wraps to way0", 32'(index_q), 10);

    cur_req = "R5";
    reg_wr(0, mk_tag(VC, 1, 0, 8'h01));
    reg_wr(1, TAG_W'(DC0));
    reg_wr(2, 29'd20);
    cmd(3);
    reg_wr(1, TAG_W'(DC1));
    reg_wr(2, 29'd21);
    cmd(4);
    cmd(1);
    chk("R5 duplicate probe", 32'(index_q), 32'h300);
    xl_chk("R12 lowest way on duplicate", VC, 8'h01, 1, DC0[25:6], DC0[5:0]);

    cur_req = "R10";
    reg_wr(2, 29'd11);
    cmd(5);
    chk("R10 read tag", 32'(tag_q), 32'(mk_tag(VB, 1, 1, 8'h07)));
    chk("R10 read data", 32'(data_q), 32'(DB));

    cur_req = "R11";
    cmd(6);
    chk("R11 invalidate pulse", 32'(uinv_pulse), 1);
    chk("R11 index unchanged", 32'(index_q), 11);

    cur_req = "R4";
    reg_wr(2, 29'd10);
    reg_wr(0, 0);
    reg_wr(1, 0);
    cmd(4);
    reg_wr(0, mk_tag(VA, 1, 0, 8'h03));
    cmd(1);
    chk("R4 zero entry is empty", 32'(index_q), 32'h200);
    xl_chk("R12 cleared entry misses", VA, 8'h03, 0, 0, 0);

    repeat (2) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule